// File: doc/BRIEF.md
# CAN Bit Timing Engine

This block turns a system clock into the bit timing of a CAN node. A programmable divider produces a time-quantum enable. A three-state sequencer advances only on that enable. Each bit starts with one synchronization quantum, then a first segment that covers propagation and phase 1, then phase segment 2. At the boundary between the first segment and phase segment 2, the block samples the receive line. It hands that sample, with a one-clock strobe, to the bit-stream processor downstream. At the same instant it captures the next bit to transmit.

The information processing time is zero. The captured transmit bit goes onto the bus line at the start of the following bit, so phase segment 2 may be programmed to a single quantum. A falling edge on the receive line counts as a synchronization edge only while the last sampled bit was recessive. A mode input chooses what such an edge does: nothing, a hard restart of the bit, or a bounded resynchronization that stretches or trims the current bit.

Top module: `can_bit_timer`

## Requirements
- R1: While reset is held, tx is 1, sample_strobe is 0 and in_sync is 1.
- R2: tq_en is high for one clock in every brp+1 clocks; with brp=0 it is high on every clock.
- R3: Without synchronization, a bit lasts (brp+1)*(tseg1+tseg2+3) clocks, measured between rising edges of in_sync. The sequencer moves only on clocks where tq_en is high.
- R4: sample_strobe is high for exactly one clock per bit, (brp+1)*(tseg1+2) clocks after in_sync rises.
- R5: sample_bit holds the value of rx seen at the sample point, and is valid from the clock on which sample_strobe is high.
- R6: tx_bit_in is captured at the sample point and appears on tx from the clock on which in_sync next rises. This also holds with tseg2=0.
- R7: While bus_off is 1, tx is 1, whatever bit has been captured.
- R8: sync_mode encoding: 0 none, 1 hard sync, 2 resync, 3 none. In the two none modes, a falling rx edge leaves the bit length unchanged.
- R9: Hard sync: when rx is 0 at a quantum enable while the last sampled bit was 1, in_sync rises on that same clock edge, whatever the current segment.
- R10: Resync in the first segment, at quantum position q (0 is the first quantum after the sync quantum): the segment is lengthened by min(q+1, sjw+1) quanta.
- R11: Resync in phase segment 2 at position q, with L = tseg2+1: the segment is shortened by min(L-q, sjw+1) quanta. When the shortened end is at or before the current position, the next bit starts at once.
- R12: At most one resync is applied per bit. No resync is applied while tx is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| brp | input | BRP_W | Quantum divider; one quantum is brp+1 clocks |
| tseg1 | input | TSEG1_W | First segment length minus one, in quanta |
| tseg2 | input | TSEG2_W | Phase segment 2 length minus one, in quanta |
| sjw | input | SJW_W | Resync jump width minus one, in quanta |
| sync_mode | input | 2 | 0 none, 1 hard, 2 resync, 3 none |
| bus_off | input | 1 | Forces tx recessive |
| rx | input | 1 | Bus receive line |
| tx_bit_in | input | 1 | Next bit to send, from the stream processor |
| tq_en | output | 1 | Time-quantum enable |
| in_sync | output | 1 | High during the sync quantum of each bit |
| sample_strobe | output | 1 | One-clock pulse at the sample point |
| sample_bit | output | 1 | Sampled bus bit |
| tx | output | 1 | Bus transmit line |

## Verification
The bench builds the block with RX_SYNC_STAGES=0. With no input synchronizer, a falling edge on rx is seen at the very next quantum enable, so each resync and hard-sync position can be placed on an exact quantum. Most scenarios use brp=0, which makes one quantum equal one clock. Lengthening, shortening, the clamp at sjw+1 and the immediate bit restart then show up directly as clock counts between in_sync rises and strobes. Other runs use brp of 1, 2 and 3, with tseg2=0, to check the divider scaling and the one-quantum phase segment 2.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
   typedef enum logic [1:0] {
      ST_SYNC = 2'd0,
      ST_SEG1 = 2'd1,
      ST_SEG2 = 2'd2
   } cbt_state_e;

   localparam logic [1:0] SM_NONE   = 2'd0;
   localparam logic [1:0] SM_HARD   = 2'd1;
   localparam logic [1:0] SM_RESYNC = 2'd2;
endpackage

// File: rtl/cbt_prescaler.sv
module cbt_prescaler #(
   parameter int BRP_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [BRP_W-1:0] brp,
   output logic             tq_en
);
   logic [BRP_W-1:0] cnt_q;

   assign tq_en = (cnt_q >= brp);

   always_ff @(posedge clk) begin
      if (!rst_n)     cnt_q <= '0;
      else if (tq_en) cnt_q <= '0;
      else            cnt_q <= cnt_q + 1'b1;
   end

   // R2: after an enable, the next clock carries another one only for brp=0
   a_r2_tq_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      tq_en |=> (brp == '0 || !tq_en));
endmodule

// File: rtl/cbt_rx_stage.sv
module cbt_rx_stage #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_in,
   output logic rx_out
);
   generate
      if (STAGES == 0) begin : g_direct
         assign rx_out = rx_in;
      end else begin : g_sync
         logic [STAGES-1:0] pipe_q;
         always_ff @(posedge clk) begin
            if (!rst_n) pipe_q <= '1;
            else begin
               pipe_q[0] <= rx_in;
               for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
            end
         end
         assign rx_out = pipe_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/cbt_phase_calc.sv
module cbt_phase_calc #(
   parameter int CNT_W = 6,
   parameter int SJW_W = 2
) (
   input  logic [CNT_W-1:0] qc,
   input  logic [CNT_W-1:0] len2,
   input  logic [SJW_W-1:0] sjw,
   output logic [CNT_W-1:0] ext_amt,
   output logic [CNT_W-1:0] sh_amt
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] jump, err_pos, err_neg;

   always_comb begin
      jump    = CNT_W'(sjw) + ONE;
      err_pos = qc + ONE;
      err_neg = len2 - qc;
      ext_amt = (err_pos < jump) ? err_pos : jump;
      sh_amt  = (err_neg < jump) ? err_neg : jump;
   end
endmodule

// File: rtl/cbt_bit_fsm.sv
module cbt_bit_fsm
   import cbt_pkg::*;
#(
   parameter int TSEG1_W = 4,
   parameter int TSEG2_W = 3,
   parameter int SJW_W   = 2,
   parameter int CNT_W   = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tq_en,
   input  logic [TSEG1_W-1:0] tseg1,
   input  logic [TSEG2_W-1:0] tseg2,
   input  logic [SJW_W-1:0]   sjw,
   input  logic [1:0]         sync_mode,
   input  logic               bus_off,
   input  logic               rx_s,
   input  logic               tx_bit_in,
   output logic               sample_strobe,
   output logic               sample_bit,
   output logic               tx,
   output logic               in_sync
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   cbt_state_e       state_q, state_n;
   logic [CNT_W-1:0] qc_q, qc_n, ext_q, ext_n, sh_q, sh_n;
   logic [CNT_W-1:0] ext_amt, sh_amt, ext_eff, sh_eff, len1, len2;
   logic             ref_q, ref_n, done_q, done_n, hold_q, hold_n, tx_q, tx_n;
   logic             strobe_n, sbit_q, sbit_n;
   logic             edge_seen, hard_ev, resync_ev, enter_sync;

   assign len1 = CNT_W'(tseg1) + ONE;
   assign len2 = CNT_W'(tseg2) + ONE;

   cbt_phase_calc #(.CNT_W(CNT_W), .SJW_W(SJW_W)) u_phase (
      .qc(qc_q), .len2(len2), .sjw(sjw), .ext_amt(ext_amt), .sh_amt(sh_amt)
   );

   assign tx        = tx_q | bus_off;
   assign in_sync   = (state_q == ST_SYNC);
   assign edge_seen = ref_q && !rx_s;
   assign hard_ev   = edge_seen && (sync_mode == SM_HARD);
   assign resync_ev = edge_seen && (sync_mode == SM_RESYNC) && !done_q && tx;
   assign ext_eff   = resync_ev ? ext_amt : ext_q;
   assign sh_eff    = resync_ev ? sh_amt  : sh_q;

   always_comb begin
      state_n    = state_q;
      qc_n       = qc_q;
      ext_n      = ext_q;
      sh_n       = sh_q;
      ref_n      = ref_q;
      done_n     = done_q;
      hold_n     = hold_q;
      tx_n       = tx_q;
      sbit_n     = sbit_q;
      strobe_n   = 1'b0;
      enter_sync = 1'b0;
      if (tq_en) begin
         if (hard_ev) begin
            enter_sync = 1'b1;
            ref_n      = 1'b0;
         end else begin
            if (resync_ev) begin
               ref_n  = 1'b0;
               done_n = 1'b1;
            end
            unique case (state_q)
               ST_SYNC: begin
                  state_n = ST_SEG1;
                  qc_n    = '0;
                  ext_n   = '0;
                  sh_n    = '0;
               end
               ST_SEG1: begin
                  ext_n = ext_eff;
                  if (qc_q == len1 + ext_eff - ONE) begin
                     state_n  = ST_SEG2;
                     qc_n     = '0;
                     strobe_n = 1'b1;
                     sbit_n   = rx_s;
                     ref_n    = rx_s;
                     hold_n   = tx_bit_in;
                  end else begin
                     qc_n = qc_q + ONE;
                  end
               end
               ST_SEG2: begin
                  sh_n = sh_eff;
                  if (qc_q + ONE >= len2 - sh_eff) enter_sync = 1'b1;
                  else                              qc_n = qc_q + ONE;
               end
               default: enter_sync = 1'b1;
            endcase
         end
         if (enter_sync) begin
            state_n = ST_SYNC;
            qc_n    = '0;
            ext_n   = '0;
            sh_n    = '0;
            done_n  = 1'b0;
            tx_n    = hold_q;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q       <= ST_SYNC;
         qc_q          <= '0;
         ext_q         <= '0;
         sh_q          <= '0;
         ref_q         <= 1'b0;
         done_q        <= 1'b0;
         hold_q        <= 1'b1;
         tx_q          <= 1'b1;
         sbit_q        <= 1'b1;
         sample_strobe <= 1'b0;
      end else begin
         state_q       <= state_n;
         qc_q          <= qc_n;
         ext_q         <= ext_n;
         sh_q          <= sh_n;
         ref_q         <= ref_n;
         done_q        <= done_n;
         hold_q        <= hold_n;
         tx_q          <= tx_n;
         sbit_q        <= sbit_n;
         sample_strobe <= strobe_n;
      end
   end

   assign sample_bit = sbit_q;

   // R3: no movement between quantum enables
   a_r3_hold_between_quanta: assert property (@(posedge clk) disable iff (!rst_n)
      !tq_en |=> ($stable(state_q) && $stable(qc_q)));
   // R4: the strobe marks entry into phase segment 2
   a_r4_strobe_in_seg2: assert property (@(posedge clk) disable iff (!rst_n)
      sample_strobe |-> (state_q == ST_SEG2));
   // R4: the strobe lasts a single clock
   a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      sample_strobe |=> !sample_strobe);
   // R6: the driven bit changes only at a bit start
   a_r6_tx_at_bit_start: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_off && !$past(bus_off) && !$stable(tx)) |-> in_sync);
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
   parameter int BRP_W          = 6,
   parameter int TSEG1_W        = 4,
   parameter int TSEG2_W        = 3,
   parameter int SJW_W          = 2,
   parameter int RX_SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [BRP_W-1:0]   brp,
   input  logic [TSEG1_W-1:0] tseg1,
   input  logic [TSEG2_W-1:0] tseg2,
   input  logic [SJW_W-1:0]   sjw,
   input  logic [1:0]         sync_mode,
   input  logic               bus_off,
   input  logic               rx,
   input  logic               tx_bit_in,
   output logic               tq_en,
   output logic               in_sync,
   output logic               sample_strobe,
   output logic               sample_bit,
   output logic               tx
);
   localparam int SEG_W = (TSEG1_W > TSEG2_W) ? TSEG1_W : TSEG2_W;
   localparam int CNT_W = SEG_W + 2;

   generate
      if (BRP_W < 1 || TSEG1_W < 1 || TSEG2_W < 1 || SJW_W < 1) begin : g_bad_width
         $error("can_bit_timer: every field width must be at least 1");
      end
      if (SJW_W > TSEG2_W) begin : g_bad_sjw
         $error("can_bit_timer: SJW_W may not exceed TSEG2_W");
      end
      if (RX_SYNC_STAGES < 0 || RX_SYNC_STAGES > 4) begin : g_bad_stages
         $error("can_bit_timer: RX_SYNC_STAGES must be 0 to 4");
      end
   endgenerate

   logic rx_s;

   cbt_prescaler #(.BRP_W(BRP_W)) u_presc (
      .clk(clk), .rst_n(rst_n), .brp(brp), .tq_en(tq_en)
   );

   cbt_rx_stage #(.STAGES(RX_SYNC_STAGES)) u_rxs (
      .clk(clk), .rst_n(rst_n), .rx_in(rx), .rx_out(rx_s)
   );

   cbt_bit_fsm #(
      .TSEG1_W(TSEG1_W), .TSEG2_W(TSEG2_W), .SJW_W(SJW_W), .CNT_W(CNT_W)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .tq_en(tq_en), .tseg1(tseg1), .tseg2(tseg2),
      .sjw(sjw), .sync_mode(sync_mode), .bus_off(bus_off), .rx_s(rx_s),
      .tx_bit_in(tx_bit_in), .sample_strobe(sample_strobe),
      .sample_bit(sample_bit), .tx(tx), .in_sync(in_sync)
   );
endmodule

// File: tb/sim_can_bit_timer.sv
`timescale 1ns/1ps
module sim_can_bit_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] brp = '0;
   logic [3:0] tseg1 = '0;
   logic [2:0] tseg2 = '0;
   logic [1:0] sjw = '0;
   logic [1:0] sync_mode = '0;
   logic       bus_off = 1'b0, rx = 1'b1, tx_bit_in = 1'b1;
   logic       tq_en, in_sync, sample_strobe, sample_bit, tx;
   int         cyc = 0;
   int         n_chk = 0, n_err = 0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   can_bit_timer #(.BRP_W(6), .TSEG1_W(4), .TSEG2_W(3), .SJW_W(2), .RX_SYNC_STAGES(0)) u0 (
      .clk(clk), .rst_n(rst_n), .brp(brp), .tseg1(tseg1), .tseg2(tseg2), .sjw(sjw),
      .sync_mode(sync_mode), .bus_off(bus_off), .rx(rx), .tx_bit_in(tx_bit_in),
      .tq_en(tq_en), .in_sync(in_sync), .sample_strobe(sample_strobe),
      .sample_bit(sample_bit), .tx(tx)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic apply(input int b, input int t1, input int t2, input int j, input int m);
      rst_n = 1'b0;
      brp = 6'(b); tseg1 = 4'(t1); tseg2 = 3'(t2); sjw = 2'(j); sync_mode = 2'(m);
      rx = 1'b1; tx_bit_in = 1'b1; bus_off = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wait_rise(output int c);
      logic p;
      p = in_sync;
      forever begin
         @(negedge clk);
         if (in_sync && !p) begin c = cyc; return; end
         p = in_sync;
      end
   endtask

   task automatic wait_strobe(output int c);
      forever begin
         @(negedge clk);
         if (sample_strobe) begin c = cyc; return; end
      end
   endtask

   task automatic wait_tq(output int c);
      forever begin
         @(negedge clk);
         if (tq_en) begin c = cyc; return; end
      end
   endtask

   task automatic t_reset;
      rst_n = 1'b0; tx_bit_in = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 tx in reset", int'(tx), 1);
      chk("R1 strobe in reset", int'(sample_strobe), 0);
      chk("R1 in_sync in reset", int'(in_sync), 1);
   endtask

   task automatic t_prescale;
      int a, b;
      apply(3, 3, 1, 0, 0);
      wait_tq(a); wait_tq(b);
      chk("R2 tq period brp=3", b - a, 4);
      apply(0, 3, 1, 0, 0);
      wait_tq(a); wait_tq(b);
      chk("R2 tq period brp=0", b - a, 1);
   endtask

   task automatic t_bitlen;
      int s, p, e;
      apply(2, 5, 2, 0, 0);
      wait_rise(s); wait_strobe(p); wait_rise(e);
      chk("R3 bit length brp=2", e - s, 30);
      chk("R4 sample offset brp=2", p - s, 21);
      apply(0, 7, 3, 0, 0);
      wait_rise(s); wait_strobe(p); wait_rise(e);
      chk("R3 bit length brp=0", e - s, 13);
      chk("R4 sample offset brp=0", p - s, 9);
   endtask

   task automatic t_sample;
      int s, p;
      apply(0, 3, 1, 0, 0);
      wait_rise(s); rx = 1'b0;
      wait_strobe(p);
      chk("R5 sampled dominant", int'(sample_bit), 0);
      rx = 1'b1;
      wait_strobe(p);
      chk("R5 sampled recessive", int'(sample_bit), 1);
   endtask

   task automatic t_tx_busoff;
      int s, p;
      apply(1, 2, 0, 0, 0);
      wait_rise(s); tx_bit_in = 1'b0;
      wait_strobe(p);
      chk("R6 tx held until bit start", int'(tx), 1);
      wait_rise(s);
      chk("R6 tx driven at bit start", int'(tx), 0);
      tx_bit_in = 1'b1;
      wait_rise(s);
      chk("R6 tx back to recessive", int'(tx), 1);
      tx_bit_in = 1'b0;
      wait_rise(s); wait_rise(s);
      bus_off = 1'b1;
      @(negedge clk);
      chk("R7 bus off forces recessive", int'(tx), 1);
      bus_off = 1'b0;
      @(negedge clk);
      chk("R7 dominant after bus off ends", int'(tx), 0);
   endtask

   task automatic t_none;
      int s, e;
      apply(0, 7, 3, 3, 0);
      wait_rise(s); repeat (4) @(negedge clk); rx = 1'b0;
      wait_rise(e);
      chk("R8 mode 0 ignores edge", e - s, 13);
      apply(0, 7, 3, 3, 3);
      wait_rise(s); repeat (4) @(negedge clk); rx = 1'b0;
      wait_rise(e);
      chk("R8 mode 3 ignores edge", e - s, 13);
   endtask

   task automatic t_hard;
      int s, e;
      apply(0, 7, 3, 0, 1);
      wait_rise(s); repeat (4) @(negedge clk); rx = 1'b0;
      wait_rise(e);
      chk("R9 hard sync restart", e - s, 5);
   endtask

   task automatic t_resync_seg1(input int m, input int exp_p, input int exp_e);
      int s, p, e;
      apply(0, 7, 3, 1, 2);
      wait_rise(s); repeat (m) @(negedge clk); rx = 1'b0;
      wait_strobe(p); wait_rise(e);
      chk("R10 lengthened sample point", p - s, exp_p);
      chk("R10 lengthened bit", e - s, exp_e);
   endtask

   task automatic t_resync_seg2(input int j, input int m, input int exp_e);
      int s, e;
      apply(0, 7, 3, j, 2);
      wait_rise(s); repeat (m) @(negedge clk); rx = 1'b0;
      wait_rise(e);
      chk("R11 shortened bit", e - s, exp_e);
   endtask

   task automatic t_once;
      int s, p, e;
      apply(0, 7, 3, 1, 2);
      wait_rise(s);
      @(negedge clk); rx = 1'b0;
      repeat (3) @(negedge clk); rx = 1'b1;
      repeat (7) @(negedge clk); rx = 1'b0;
      wait_rise(e);
      chk("R12 single resync per bit", e - s, 14);
      apply(0, 7, 3, 1, 2);
      wait_rise(s); tx_bit_in = 1'b0;
      wait_rise(s);
      @(negedge clk); rx = 1'b0;
      wait_strobe(p);
      chk("R12 no resync while sending dominant", p - s, 9);
   endtask

   initial begin
      t_reset();
      t_prescale();
      t_bitlen();
      t_sample();
      t_tx_busoff();
      t_none();
      t_hard();
      t_resync_seg1(1, 10, 14);
      t_resync_seg1(5, 11, 15);
      t_resync_seg2(1, 10, 11);
      t_resync_seg2(0, 9, 12);
      t_once();
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule